// File: doc/BRIEF.md
# Processor Exception Entry and Return Sequencer

This block takes exceptions into and out of a small 32-bit processor core. Each cycle it looks at seven request lines: reset, undefined instruction, software trap, instruction-fetch abort, data abort, normal interrupt and fast interrupt. It drops any interrupt whose disable bit is set in the status word and picks one of the remaining requests by a fixed priority. It then enters that exception in a single clock. The return address and the old status word go into the target mode's own banked registers. The status word is rewritten by a fixed recipe and the vector address is issued together with a load pulse.

The core asserts the return strobe at the end of a handler. The block then restores the status word from the current mode's saved copy and loads the PC from that mode's link register, both in the same clock. On a software trap the block also captures the low 20 bits of the trapping instruction, so that the handler can dispatch on the trap number. The core writes ordinary status updates, such as flag changes, through a write port. Exception entry and return both take precedence over that port.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Synchronous reset sets the status word to 0x00000010 (user mode, both interrupt disables clear). It also clears `pc_out`, `pc_load`, `exc_taken` and `swi_num`.
- R2: Only one exception is entered per cycle. The priority from highest to lowest is reset, data abort, fast interrupt, normal interrupt, fetch abort, undefined instruction, software trap.
- R3: A normal-interrupt request is ignored while status bit 7 is 1. A fast-interrupt request is ignored while status bit 6 is 1. No other request is masked.
- R4: On entry, status bits 4:0 become the target mode, bit 5 is cleared and bit 7 is set. Bits 31:8 are kept.
- R5: On entry, status bit 6 is set for reset and fast interrupt. For every other exception it keeps its value.
- R6: Target modes and vectors: reset 10011 @0x00, undefined 11011 @0x04, software trap 10011 @0x08, fetch abort 10111 @0x0C, data abort 10111 @0x10, normal interrupt 10010 @0x18, fast interrupt 10001 @0x1C. User mode is 10000.
- R7: On entry, the target mode's link register receives `cur_pc`+8 and its saved status register receives the status word as it was before entry.
- R8: While in a banked mode, a return strobe restores the status word from that mode's saved status and loads `pc_out` from that mode's link register. Both happen in the same cycle, with `pc_load` high and `exc_taken` low.
- R9: A return strobe is ignored when the current mode has no bank (user or any unlisted mode). Outputs hold and `pc_load` stays low.
- R10: If an exception is taken in the same cycle as a return strobe or a status write, the entry wins and the other operation is dropped.
- R11: On a software-trap entry, `swi_num` takes `instr[19:0]`. At all other times it holds its value.
- R12: When no entry or return happens, `psr_we` loads `psr_wdata` into the status word.
- R13: All outputs are registered and reflect the inputs one clock edge later. `exc_taken` and `pc_load` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_reset | input | 1 | Reset exception request |
| req_undef | input | 1 | Undefined instruction request |
| req_swi | input | 1 | Software trap request |
| req_pabt | input | 1 | Instruction-fetch abort request |
| req_dabt | input | 1 | Data abort request |
| req_irq | input | 1 | Normal interrupt request |
| req_fiq | input | 1 | Fast interrupt request |
| cur_pc | input | 32 | Address of the current instruction |
| instr | input | 32 | Current instruction word (trap number source) |
| ret_strobe | input | 1 | Return-from-exception strobe |
| psr_we | input | 1 | Status word write enable |
| psr_wdata | input | 32 | Status word write data |
| status | output | 32 | Current status word |
| pc_out | output | 32 | Vector or return address |
| pc_load | output | 1 | Pulse: core loads `pc_out` |
| exc_taken | output | 1 | Pulse: an exception was entered |
| swi_num | output | 20 | Captured software trap number |

## Verification
The functions that can collide in one cycle are exception entry and return, and also entry and a status write. Both collisions can disturb the banked registers and the status word. The bench raises a request and the return strobe, or `psr_we`, on the same edge. It does this in directed steps and also throughout a long random phase. It judges the outcome by comparing the status word, the PC and the pulses against a behavioural model. A later return then shows whether the dropped return corrupted the bank contents.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int NUM_EXC = 7;
  localparam int NUM_BANK = 5;
  localparam int BANK_W = $clog2(NUM_BANK + 1);
  localparam logic [BANK_W-1:0] NO_BANK = BANK_W'(NUM_BANK);

  // Enum order is the arbitration priority (lowest value wins).
  typedef enum logic [2:0] {
    EX_RESET = 3'd0,
    EX_DABT  = 3'd1,
    EX_FIQ   = 3'd2,
    EX_IRQ   = 3'd3,
    EX_PABT  = 3'd4,
    EX_UNDEF = 3'd5,
    EX_SWI   = 3'd6
  } exc_e;

  localparam logic [4:0] MODE_USR = 5'b10000;
  localparam logic [4:0] MODE_FIQ = 5'b10001;
  localparam logic [4:0] MODE_IRQ = 5'b10010;
  localparam logic [4:0] MODE_SVC = 5'b10011;
  localparam logic [4:0] MODE_ABT = 5'b10111;
  localparam logic [4:0] MODE_UND = 5'b11011;

  localparam int BIT_IDIS  = 7;
  localparam int BIT_FDIS  = 6;
  localparam int BIT_THUMB = 5;

  function automatic logic [4:0] mode_of(exc_e e);
    case (e)
      EX_RESET, EX_SWI: mode_of = MODE_SVC;
      EX_UNDEF:         mode_of = MODE_UND;
      EX_PABT, EX_DABT: mode_of = MODE_ABT;
      EX_IRQ:           mode_of = MODE_IRQ;
      default:          mode_of = MODE_FIQ;
    endcase
  endfunction

  function automatic logic [7:0] vec_of(exc_e e);
    case (e)
      EX_RESET: vec_of = 8'h00;
      EX_UNDEF: vec_of = 8'h04;
      EX_SWI:   vec_of = 8'h08;
      EX_PABT:  vec_of = 8'h0C;
      EX_DABT:  vec_of = 8'h10;
      EX_IRQ:   vec_of = 8'h18;
      default:  vec_of = 8'h1C;
    endcase
  endfunction

  function automatic logic [BANK_W-1:0] bank_of(logic [4:0] m);
    case (m)
      MODE_SVC: bank_of = BANK_W'(0);
      MODE_ABT: bank_of = BANK_W'(1);
      MODE_UND: bank_of = BANK_W'(2);
      MODE_IRQ: bank_of = BANK_W'(3);
      MODE_FIQ: bank_of = BANK_W'(4);
      default:  bank_of = NO_BANK;
    endcase
  endfunction
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter #(
  parameter int N = 7,
  localparam int SW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic          irq_mask,
  input  logic          fiq_mask,
  output logic          valid,
  output logic [SW-1:0] sel,
  output logic [N-1:0]  grant
);
  import exc_pkg::*;

  logic [N-1:0] live;

  generate
    for (genvar i = 0; i < N; i++) begin : g_mask
      if (i == int'(EX_IRQ)) begin : g_irq
        assign live[i] = req[i] & ~irq_mask;
      end else if (i == int'(EX_FIQ)) begin : g_fiq
        assign live[i] = req[i] & ~fiq_mask;
      end else begin : g_plain
        assign live[i] = req[i];
      end
    end
  endgenerate

  always_comb begin
    valid = 1'b0;
    sel   = '0;
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (live[i]) begin
        valid = 1'b1;
        sel   = SW'(i);
      end
    end
    if (valid) grant[sel] = 1'b1;
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst) $onehot0(grant)); // R2
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst) grant[EX_IRQ] |-> !irq_mask); // R3
  AST_FIQ_MASKED: assert property (@(posedge clk) disable iff (rst) grant[EX_FIQ] |-> !fiq_mask); // R3
endmodule

// File: rtl/exc_bank.sv
module exc_bank #(
  parameter int NBANK = 5,
  parameter int W     = 32,
  localparam int IW   = $clog2(NBANK + 1)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_link,
  input  logic [W-1:0]  wr_psr,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_link,
  output logic [W-1:0]  rd_psr
);
  logic [W-1:0] link_mem [NBANK];
  logic [W-1:0] psr_mem  [NBANK];

  always_ff @(posedge clk) begin
    if (wr_en && (int'(wr_idx) < NBANK)) begin
      link_mem[wr_idx] <= wr_link;
      psr_mem[wr_idx]  <= wr_psr;
    end
  end

  always_comb begin
    rd_link = '0;
    rd_psr  = '0;
    if (int'(rd_idx) < NBANK) begin
      rd_link = link_mem[rd_idx];
      rd_psr  = psr_mem[rd_idx];
    end
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl #(
  parameter int          XLEN      = 32,
  parameter int          SWI_W     = 20,
  parameter int          PC_OFFSET = 8,
  parameter logic [31:0] VEC_BASE  = 32'h0000_0000,
  parameter logic [31:0] PSR_INIT  = 32'h0000_0010
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_reset,
  input  logic             req_undef,
  input  logic             req_swi,
  input  logic             req_pabt,
  input  logic             req_dabt,
  input  logic             req_irq,
  input  logic             req_fiq,
  input  logic [XLEN-1:0]  cur_pc,
  input  logic [XLEN-1:0]  instr,
  input  logic             ret_strobe,
  input  logic             psr_we,
  input  logic [XLEN-1:0]  psr_wdata,
  output logic [XLEN-1:0]  status,
  output logic [XLEN-1:0]  pc_out,
  output logic             pc_load,
  output logic             exc_taken,
  output logic [SWI_W-1:0] swi_num
);
  import exc_pkg::*;

  localparam int SW = $clog2(NUM_EXC);

  logic [NUM_EXC-1:0] req_vec, grant;
  logic               ent_valid;
  logic [SW-1:0]      ent_sel;
  exc_e               ent_exc;
  logic [4:0]         ent_mode;
  logic [XLEN-1:0]    ent_psr, ent_vec;
  logic [BANK_W-1:0]  cur_bank;
  logic               ret_ok;
  logic [XLEN-1:0]    bank_link, bank_psr;

  // Index of each bit equals the priority rank in exc_e.
  assign req_vec = {req_swi, req_undef, req_pabt, req_irq, req_fiq, req_dabt, req_reset};

  exc_arbiter #(.N(NUM_EXC)) u_arb (
    .clk      (clk),
    .rst      (rst),
    .req      (req_vec),
    .irq_mask (status[BIT_IDIS]),
    .fiq_mask (status[BIT_FDIS]),
    .valid    (ent_valid),
    .sel      (ent_sel),
    .grant    (grant)
  );

  assign ent_exc  = exc_e'(ent_sel);
  assign ent_mode = mode_of(ent_exc);
  assign ent_vec  = VEC_BASE + XLEN'(vec_of(ent_exc));

  always_comb begin
    ent_psr            = status;
    ent_psr[4:0]       = ent_mode;
    ent_psr[BIT_THUMB] = 1'b0;
    ent_psr[BIT_IDIS]  = 1'b1;
    if (grant[EX_RESET] || grant[EX_FIQ]) ent_psr[BIT_FDIS] = 1'b1;
  end

  assign cur_bank = bank_of(status[4:0]);
  assign ret_ok   = ret_strobe && !ent_valid && (cur_bank != NO_BANK);

  exc_bank #(.NBANK(NUM_BANK), .W(XLEN)) u_bank (
    .clk     (clk),
    .wr_en   (ent_valid && !rst),
    .wr_idx  (bank_of(ent_mode)),
    .wr_link (cur_pc + XLEN'(PC_OFFSET)),
    .wr_psr  (status),
    .rd_idx  (cur_bank),
    .rd_link (bank_link),
    .rd_psr  (bank_psr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      status    <= XLEN'(PSR_INIT);
      pc_out    <= '0;
      pc_load   <= 1'b0;
      exc_taken <= 1'b0;
      swi_num   <= '0;
    end else begin
      exc_taken <= ent_valid;
      pc_load   <= ent_valid || ret_ok;
      if (ent_valid) begin
        status <= ent_psr;
        pc_out <= ent_vec;
        if (grant[EX_SWI]) swi_num <= instr[SWI_W-1:0];
      end else if (ret_ok) begin
        status <= bank_psr;
        pc_out <= bank_link;
      end else if (psr_we) begin
        status <= psr_wdata;
      end
    end
  end

  AST_ENTRY_BITS: assert property (@(posedge clk) disable iff (rst)
    exc_taken |-> (status[BIT_IDIS] && !status[BIT_THUMB])); // R4
  AST_RET_SOURCE: assert property (@(posedge clk) disable iff (rst)
    (pc_load && !exc_taken) |-> $past(ret_strobe)); // R8
  AST_FIQ_FDIS: assert property (@(posedge clk) disable iff (rst)
    (exc_taken && pc_out == VEC_BASE + XLEN'(8'h1C)) |-> status[BIT_FDIS]); // R5
  AST_TAKEN_LOAD: assert property (@(posedge clk) disable iff (rst)
    exc_taken |-> pc_load); // R13
endmodule

// File: tb/exc_entry_ctrl_bench.sv
module exc_entry_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_reset = 0, req_undef = 0, req_swi = 0, req_pabt = 0;
  logic req_dabt = 0, req_irq = 0, req_fiq = 0;
  logic [31:0] cur_pc = 0, instr = 0, psr_wdata = 0;
  logic ret_strobe = 0, psr_we = 0;
  logic [31:0] status, pc_out;
  logic pc_load, exc_taken;
  logic [19:0] swi_num;

  int errors = 0;
  int checks = 0;

  // reference state
  logic [31:0] m_st, m_pc;
  logic m_ld, m_tk;
  logic [19:0] m_sw;
  logic [31:0] m_link [32];
  logic [31:0] m_spsr [32];
  string tag;

  always #10 clk = ~clk;

  exc_entry_ctrl u_exc_entry_ctrl (
    .clk(clk), .rst(rst),
    .req_reset(req_reset), .req_undef(req_undef), .req_swi(req_swi),
    .req_pabt(req_pabt), .req_dabt(req_dabt), .req_irq(req_irq), .req_fiq(req_fiq),
    .cur_pc(cur_pc), .instr(instr), .ret_strobe(ret_strobe),
    .psr_we(psr_we), .psr_wdata(psr_wdata),
    .status(status), .pc_out(pc_out), .pc_load(pc_load),
    .exc_taken(exc_taken), .swi_num(swi_num)
  );

  task automatic chk(string t, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", t, what, act, exp);
    end
  endtask

  function automatic bit banked(logic [4:0] m);
    return m == 5'b10011 || m == 5'b10111 || m == 5'b11011 ||
           m == 5'b10010 || m == 5'b10001;
  endfunction

  task automatic model_step();
    int code;
    logic [4:0] md;
    logic [31:0] vc, ns;
    if (rst) begin
      m_st = 32'h10; m_pc = 0; m_ld = 0; m_tk = 0; m_sw = 0; tag = "R1";
      return;
    end
    code = -1;
    if (req_reset) code = 0;
    else if (req_dabt) code = 1;
    else if (req_fiq && !m_st[6]) code = 2;
    else if (req_irq && !m_st[7]) code = 3;
    else if (req_pabt) code = 4;
    else if (req_undef) code = 5;
    else if (req_swi) code = 6;
    if (code >= 0) begin
      case (code)
        0: begin md = 5'b10011; vc = 32'h00; end
        1: begin md = 5'b10111; vc = 32'h10; end
        2: begin md = 5'b10001; vc = 32'h1C; end
        3: begin md = 5'b10010; vc = 32'h18; end
        4: begin md = 5'b10111; vc = 32'h0C; end
        5: begin md = 5'b11011; vc = 32'h04; end
        default: begin md = 5'b10011; vc = 32'h08; end
      endcase
      m_link[md] = cur_pc + 8;
      m_spsr[md] = m_st;
      ns = m_st; ns[4:0] = md; ns[5] = 0; ns[7] = 1;
      if (code == 0 || code == 2) ns[6] = 1;
      m_st = ns; m_pc = vc; m_tk = 1; m_ld = 1;
      if (code == 6) m_sw = instr[19:0];
      if (ret_strobe || psr_we) tag = "R10";
      else if (code == 0 || code == 2) tag = "R5";
      else if (code == 3) tag = "R3";
      else tag = "R4";
    end else if (ret_strobe && banked(m_st[4:0])) begin
      md = m_st[4:0];
      m_st = m_spsr[md]; m_pc = m_link[md]; m_ld = 1; m_tk = 0; tag = "R8";
    end else begin
      m_ld = 0; m_tk = 0;
      if (psr_we) m_st = psr_wdata;
      tag = ret_strobe ? "R9" : (psr_we ? "R12" : "R13");
    end
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    #5;
    chk(tag, "status", status, m_st);
    chk(tag, "pc_out", pc_out, m_pc);
    chk(tag, "pc_load", 32'(pc_load), 32'(m_ld));
    chk(tag, "exc_taken", 32'(exc_taken), 32'(m_tk));
    chk(tag, "swi_num", 32'(swi_num), 32'(m_sw));
  endtask

  task automatic idle_inputs();
    {req_reset, req_undef, req_swi, req_pabt, req_dabt, req_irq, req_fiq} = '0;
    ret_strobe = 0; psr_we = 0;
  endtask

  initial begin : watchdog
    #3_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) begin m_link[i] = 0; m_spsr[i] = 0; end
    rst = 1; tick(); tick();
    chk("R1", "reset status", status, 32'h0000_0010);
    rst = 0;

    // R12: flag write in user mode
    psr_we = 1; psr_wdata = 32'hF000_0010; tick(); idle_inputs();

    // R11/R6/R7: software trap at 0xFEED0000
    cur_pc = 32'hFEED_0000; instr = 32'hEF00_F001; req_swi = 1; tick(); idle_inputs();
    chk("R6", "swi vector", pc_out, 32'h8);
    chk("R4", "svc status", status, 32'hF000_0093);
    chk("R11", "trap number", 32'(swi_num), 32'h0_F001);
    ret_strobe = 1; tick(); idle_inputs();
    chk("R7", "swi return address", pc_out, 32'hFEED_0008);
    chk("R8", "restored status", status, 32'hF000_0010);

    // R2: fiq and irq together, fiq wins; then irq masked inside fiq
    req_fiq = 1; req_irq = 1; cur_pc = 32'h100; tick();
    chk("R2", "fiq over irq", pc_out, 32'h1C);
    tick(); // R3: both still requesting, masked now
    chk("R3", "masked no entry", 32'(exc_taken), 0);
    idle_inputs(); ret_strobe = 1; tick(); idle_inputs();

    // R2: all requests together -> reset
    {req_reset, req_undef, req_swi, req_pabt, req_dabt, req_irq, req_fiq} = '1;
    tick(); idle_inputs();
    chk("R2", "reset wins", pc_out, 32'h0);
    ret_strobe = 1; tick(); idle_inputs();

    // R2: aborts and undefined
    req_pabt = 1; req_dabt = 1; req_undef = 1; cur_pc = 32'h200; tick(); idle_inputs();
    chk("R2", "dabt first", pc_out, 32'h10);
    ret_strobe = 1; tick(); idle_inputs();

    // R9: return in user mode ignored
    ret_strobe = 1; tick(); idle_inputs();
    chk("R9", "user return no load", 32'(pc_load), 0);

    // R10: entry with return and write in same cycle; nested return chain
    req_swi = 1; cur_pc = 32'h300; tick(); idle_inputs();
    req_undef = 1; ret_strobe = 1; psr_we = 1; psr_wdata = 32'h10; cur_pc = 32'h400;
    tick(); idle_inputs();
    chk("R10", "undef entry wins", pc_out, 32'h04);
    ret_strobe = 1; tick();
    chk("R8", "back to svc", pc_out, 32'h408);
    tick(); idle_inputs();
    chk("R8", "back to user", pc_out, 32'h308);

    // random phase
    for (int n = 0; n < 2000; n++) begin
      idle_inputs();
      req_reset = ($urandom_range(0, 99) < 2);
      req_undef = ($urandom_range(0, 99) < 6);
      req_swi   = ($urandom_range(0, 99) < 6);
      req_pabt  = ($urandom_range(0, 99) < 5);
      req_dabt  = ($urandom_range(0, 99) < 5);
      req_irq   = ($urandom_range(0, 99) < 10);
      req_fiq   = ($urandom_range(0, 99) < 8);
      ret_strobe = ($urandom_range(0, 99) < 35);
      psr_we    = ($urandom_range(0, 99) < 10);
      psr_wdata = {$urandom_range(0, 31), 19'h0, 2'($urandom_range(0, 3)), 1'b0, 5'b10000};
      cur_pc    = {$urandom_range(0, 32'h3FFF_FFFF), 2'b00};
      instr     = $urandom;
      tick();
    end
    idle_inputs();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule